// File: doc/BRIEF.md
# Sliced VBI Ancillary Packet Parser

This block sits on an 8-bit video-port byte stream and picks out the ancillary packets that carry sliced vertical-blanking data. Horizontal timing codes, line status bytes and idle filler all pass through unreported until the three-byte start sequence `00 FF FF` appears. The block then reads a short header. That header gives the field, the kind of service the slicer found, the payload length and the video line the data came from.

The payload region is forwarded byte by byte on a valid/ready output. When a packet ends, a one-cycle `done` strobe presents the service type, the line number (with a programmable offset added) and the field flag. For caption packets it also checks the parity of the first two payload bytes. Any error forces the reported type, line and field to zero and raises `err`. VPS payloads are only labelled as VPS; biphase decoding and checksum checking are left to later logic.

Back-pressure rules: an input byte is taken on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while a forwarded payload byte is waiting (`out_valid` high, `out_ready` low). While waiting, `out_data` holds its value. `done` and its fields are plain status with no handshake.

Top module: `vbi_anc_parser`

## Requirements
- R1: Before a `00 FF FF` start sequence, input bytes (timing codes, status bytes, idle bytes) produce no `out_valid` and no `done`.
- R2: The identifier byte after the start sequence selects the field. 0x91 reports `field2`=0 and 0x55 reports `field2`=1.
- R3: Any other identifier byte ends the packet at once: `done` pulses one cycle after that byte with `err`=1. No payload is forwarded.
- R4: The low nibble of the second header byte maps to `svc_type`: 1 gives 1 (teletext B), 4 gives 2 (625-line WSS), 6 gives 3 (525-line caption) and 9 gives 4 (VPS). Every other nibble is an error.
- R5: The low 6 bits of the third header byte, times four, give the payload length. After two internal-identifier bytes, exactly that many bytes are forwarded in order. `done` pulses in the cycle after the last of them is taken, or after the second internal-identifier byte when the length is zero.
- R6: The reported `line` is the low 6 bits of the first internal-identifier byte plus `line_offset`, sampled when that byte is taken.
- R7: In a caption packet, payload bytes 0 and 1 must each have an odd number of one bits. A caption packet with zero length is an error.
- R8: Whenever `done` reports `err`=1, `svc_type`, `line` and `field2` are 0. Whenever `err`=0, `svc_type` is nonzero.
- R9: A start sequence seen mid-packet abandons that packet without a `done` and restarts header parsing. The final 0xFF of the sequence is not forwarded; earlier bytes taken in the payload state are forwarded.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` stays unchanged.
- R11: After reset, `out_valid` and `done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Video-port byte |
| line_offset | input | OFFS_W (4) | Added to the embedded line number |
| out_valid | output | 1 | Payload byte present |
| out_ready | input | 1 | Consumer takes the payload byte |
| out_data | output | 8 | Payload byte |
| done | output | 1 | One-cycle end-of-packet strobe |
| svc_type | output | 3 | Service type: 0 none, 1 teletext B, 2 WSS, 3 caption, 4 VPS |
| line | output | LINE_W (7) | Line number plus offset |
| field2 | output | 1 | Packet belongs to the second field |
| err | output | 1 | Packet rejected |

## Verification
Directed packets cover each service code and both field identifiers. They also cover a wrong identifier, an unknown service nibble, each caption parity byte made wrong, and zero-length caption and non-caption packets. Together these separate the length, parity and error-masking paths. Start sequences are injected after one and after two header bytes and in mid-payload, which tests whether an abort resyncs or leaks a report. Random packets with random timing gaps, random idle filler and random output back-pressure run under three line offsets, including the largest offset with the largest line number. This checks that stalls never drop, repeat or reorder payload bytes and that the line sum does not wrap.

// File: rtl/vbi_anc_pkg.sv
package vbi_anc_pkg;

  typedef enum logic [2:0] {
    SVC_NONE = 3'd0,
    SVC_TTX  = 3'd1,
    SVC_WSS  = 3'd2,
    SVC_CC   = 3'd3,
    SVC_VPS  = 3'd4
  } svc_e;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_DID,
    ST_SDID,
    ST_CNT,
    ST_ID0,
    ST_ID1,
    ST_PAY
  } pst_e;

  localparam logic [7:0] START_LO  = 8'h00;
  localparam logic [7:0] START_HI  = 8'hFF;
  localparam logic [7:0] ID_FIELD1 = 8'h91;
  localparam logic [7:0] ID_FIELD2 = 8'h55;

  function automatic logic has_odd_ones(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/vbi_start_det.sv
module vbi_start_det #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              hit
);
  import vbi_anc_pkg::*;

  logic [BYTE_W-1:0] hist1, hist2;

  assign hit = (hist2 == START_LO) && (hist1 == START_HI) && (byte_i == START_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist1 <= '1;
      hist2 <= '1;
    end else if (take) begin
      hist2 <= hist1;
      hist1 <= byte_i;
    end
  end
endmodule

// File: rtl/vbi_svc_map.sv
module vbi_svc_map (
  input  logic             [3:0] code,
  output vbi_anc_pkg::svc_e      svc,
  output logic                   known
);
  import vbi_anc_pkg::*;

  always_comb begin
    known = 1'b1;
    case (code)
      4'd1:    svc = SVC_TTX;
      4'd4:    svc = SVC_WSS;
      4'd6:    svc = SVC_CC;
      4'd9:    svc = SVC_VPS;
      default: begin
        svc   = SVC_NONE;
        known = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/vbi_anc_parser.sv
module vbi_anc_parser #(
  parameter int OFFS_W = 4,
  parameter int LN_W   = 6,
  parameter int CNT_W  = 6,
  localparam int LINE_W = ((OFFS_W > LN_W) ? OFFS_W : LN_W) + 1,
  localparam int REG_W  = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [OFFS_W-1:0] line_offset,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              done,
  output logic [2:0]        svc_type,
  output logic [LINE_W-1:0] line,
  output logic              field2,
  output logic              err
);
  import vbi_anc_pkg::*;

  pst_e              st;
  svc_e              pk_type;
  svc_e              map_svc;
  logic              map_known;
  logic              pk_err;
  logic              pk_fld;
  logic [LINE_W-1:0] pk_line;
  logic [REG_W-1:0]  region;
  logic [REG_W-1:0]  idx;
  logic              fire, start_hit;
  logic              fin, fin_err, bad_par;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  vbi_start_det #(.BYTE_W(8)) u_start (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (fire),
    .byte_i (in_data),
    .hit    (start_hit)
  );

  vbi_svc_map u_map (
    .code  (in_data[3:0]),
    .svc   (map_svc),
    .known (map_known)
  );

  // End-of-packet decision for the byte taken this cycle
  always_comb begin
    fin     = 1'b0;
    fin_err = 1'b0;
    bad_par = (pk_type == SVC_CC) && (idx < REG_W'(2)) && !has_odd_ones(in_data);
    if (fire && !start_hit) begin
      case (st)
        ST_DID: begin
          if (in_data != ID_FIELD1 && in_data != ID_FIELD2) begin
            fin     = 1'b1;
            fin_err = 1'b1;
          end
        end
        ST_ID1: begin
          if (region == '0) begin
            fin     = 1'b1;
            fin_err = pk_err || (pk_type == SVC_CC);
          end
        end
        ST_PAY: begin
          if (idx == region - REG_W'(1)) begin
            fin     = 1'b1;
            fin_err = pk_err || bad_par;
          end
        end
        default: ;
      endcase
    end
  end

  // Packet state machine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_HUNT;
      pk_type <= SVC_NONE;
      pk_err  <= 1'b0;
      pk_fld  <= 1'b0;
      pk_line <= '0;
      region  <= '0;
      idx     <= '0;
    end else if (fire) begin
      if (start_hit) begin
        st     <= ST_DID;
        pk_err <= 1'b0;
      end else begin
        case (st)
          ST_DID: begin
            pk_fld <= (in_data == ID_FIELD2);
            st     <= fin ? ST_HUNT : ST_SDID;
          end
          ST_SDID: begin
            pk_type <= map_svc;
            pk_err  <= !map_known;
            st      <= ST_CNT;
          end
          ST_CNT: begin
            region <= {in_data[CNT_W-1:0], 2'b00};
            st     <= ST_ID0;
          end
          ST_ID0: begin
            pk_line <= LINE_W'(in_data[LN_W-1:0]) + LINE_W'(line_offset);
            st      <= ST_ID1;
          end
          ST_ID1: begin
            idx <= '0;
            st  <= fin ? ST_HUNT : ST_PAY;
          end
          ST_PAY: begin
            idx    <= idx + REG_W'(1);
            pk_err <= pk_err || bad_par;
            if (fin) st <= ST_HUNT;
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end

  // Payload output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fire && !start_hit && st == ST_PAY) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end
    end
  end

  // End-of-packet report
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      err      <= 1'b0;
      svc_type <= '0;
      line     <= '0;
      field2   <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        err      <= fin_err;
        svc_type <= fin_err ? 3'd0 : pk_type;
        line     <= fin_err ? '0 : pk_line;
        field2   <= fin_err ? 1'b0 : pk_fld;
      end
    end
  end
endmodule

// File: rtl/vbi_anc_parser_chk.sv
module vbi_anc_parser_chk #(
  parameter int LINE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              done,
  input logic [2:0]        svc_type,
  input logic [LINE_W-1:0] line,
  input logic              field2,
  input logic              err
);

  // R10: a stalled payload byte stays put
  a_r10_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10: input is held off while the output is stalled
  a_r10_stall_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R8: an error report carries zeros
  a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> svc_type == 3'd0 && line == '0 && !field2);

  // R8: a clean report carries a known service
  a_r8_ok_type: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> svc_type != 3'd0 && svc_type <= 3'd4);

  // R5: the end strobe lasts one cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind vbi_anc_parser vbi_anc_parser_chk #(.LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done),
  .svc_type  (svc_type),
  .line      (line),
  .field2    (field2),
  .err       (err)
);

// File: tb/vbi_anc_parser_tb.sv
module vbi_anc_parser_tb;
  localparam int OFFS_W = 4;
  localparam int LINE_W = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [7:0]        in_data, out_data;
  logic [OFFS_W-1:0] line_offset;
  logic              done, field2, err;
  logic [2:0]        svc_type;
  logic [LINE_W-1:0] line;

  vbi_anc_parser u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .line_offset(line_offset), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .done(done),
    .svc_type(svc_type), .line(line), .field2(field2), .err(err)
  );

  typedef struct {
    logic [2:0]        t;
    logic [LINE_W-1:0] l;
    logic              f;
    logic              e;
    string             tag;
  } rec_t;

  logic [7:0] stim_q[$];
  logic [7:0] exp_pay[$];
  rec_t       exp_done[$];
  int n_chk = 0, n_bad = 0, cyc = 0, cur_offs = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R5 watchdog: cycles %0d expected under %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [2:0] ref_svc(input int nib);
    case (nib)
      1: return 3'd1;
      4: return 3'd2;
      6: return 3'd3;
      9: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] rnd_byte();
    return 8'($urandom_range(1, 254));
  endfunction

  function automatic logic [7:0] par_byte(input bit odd);
    logic [7:0] b;
    do b = rnd_byte(); while ((^b) != odd);
    return b;
  endfunction

  // Timing code, status byte and idle filler ahead of a packet (R1)
  task automatic add_gap(input int n);
    logic [7:0] st_codes[4] = '{8'hB0, 8'hF0, 8'h90, 8'hD0};
    stim_q.push_back(8'hFF); stim_q.push_back(8'h00); stim_q.push_back(8'h00);
    stim_q.push_back(st_codes[$urandom_range(0, 3)]);
    for (int i = 0; i < n; i++) stim_q.push_back(rnd_byte());
  endtask

  // cc_bad: 0 none, 1 byte 0 wrong, 2 byte 1 wrong. abort_k: -1 none, else bytes after start
  task automatic add_pkt(input logic [7:0] did, input int nib, input int cnt, input int ln,
                         input int cc_bad, input int abort_k, input string tag);
    logic [7:0] pk[$];
    logic [7:0] pay[$];
    rec_t r;
    bit good_id, e;
    pk = '{8'h00, 8'hFF, 8'hFF, did, {4'b0100, 4'(nib)}, {2'b01, 6'(cnt)}, {2'b10, 6'(ln)}, 8'h80};
    for (int i = 0; i < 4 * cnt; i++) begin
      if (nib == 6 && i < 2) pay.push_back(par_byte(cc_bad != i + 1));
      else pay.push_back(rnd_byte());
    end
    good_id = (did == 8'h91) || (did == 8'h55);
    if (abort_k >= 0) begin
      for (int i = 0; i < 3 + abort_k && i < 8; i++) stim_q.push_back(pk[i]);
      for (int i = 0; i < abort_k - 5; i++) begin
        stim_q.push_back(pay[i]);
        exp_pay.push_back(pay[i]);
      end
      if (abort_k > 5) begin
        exp_pay.push_back(8'h00);
        exp_pay.push_back(8'hFF);
      end
      return;
    end
    foreach (pk[i]) if (good_id || i < 4) stim_q.push_back(pk[i]);
    if (!good_id) begin
      r.t = 0; r.l = 0; r.f = 0; r.e = 1; r.tag = tag;
      exp_done.push_back(r);
      return;
    end
    foreach (pay[i]) begin
      stim_q.push_back(pay[i]);
      exp_pay.push_back(pay[i]);
    end
    e = (ref_svc(nib) == 0) || (nib == 6 && (cnt == 0 || cc_bad != 0));
    r.e = e;
    r.t = e ? 3'd0 : ref_svc(nib);
    r.l = e ? '0 : LINE_W'(ln + cur_offs);
    r.f = e ? 1'b0 : (did == 8'h55);
    r.tag = tag;
    exp_done.push_back(r);
  endtask

  task automatic chk_done();
    rec_t r;
    n_chk++;
    if (exp_done.size() == 0) begin
      n_bad++;
      $display("FAIL R9 unexpected done: got type %0d line %0d, expected no report", svc_type, line);
      return;
    end
    r = exp_done.pop_front();
    if (svc_type != r.t || line != r.l || field2 != r.f || err != r.e) begin
      n_bad++;
      $display("FAIL %s: got type %0d line %0d field %0d err %0d, expected %0d %0d %0d %0d",
               r.tag, svc_type, line, field2, err, r.t, r.l, r.f, r.e);
    end
  endtask

  task automatic chk_pay();
    logic [7:0] x;
    n_chk++;
    if (exp_pay.size() == 0) begin
      n_bad++;
      $display("FAIL R5 extra payload: got %02h, expected none", out_data);
      return;
    end
    x = exp_pay.pop_front();
    if (out_data !== x) begin
      n_bad++;
      $display("FAIL R5 R10 payload: got %02h, expected %02h", out_data, x);
    end
  endtask

  task automatic run_phase(input int offs);
    int drain = 0;
    line_offset = OFFS_W'(offs);
    while (drain < 40) begin
      @(negedge clk);
      if (stim_q.size() == 0) drain++;
      out_ready = (drain > 0) ? 1'b1 : ($urandom_range(0, 3) != 0);
      if (stim_q.size() > 0 && $urandom_range(0, 4) != 0) begin
        in_valid = 1'b1;
        in_data  = stim_q[0];
      end else in_valid = 1'b0;
      #1;
      if (done) chk_done();
      if (out_valid && out_ready) chk_pay();
      if (in_valid && in_ready) void'(stim_q.pop_front());
    end
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0; line_offset = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || done !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R11 reset: got out_valid %0b done %0b in_ready %0b, expected 0 0 1",
               out_valid, done, in_ready);
    end

    // Phase A: directed, offset 0
    cur_offs = 0;
    add_gap(5);
    stim_q.push_back(8'h00); stim_q.push_back(8'hFF); stim_q.push_back(8'h12); // R1 near miss
    add_pkt(8'h91, 1, 3, 7, 0, -1, "R1 R5 teletext field 1");
    add_gap(2);  add_pkt(8'h55, 4, 1, 23, 0, -1, "R2 wss field 2");
    add_gap(0);  add_pkt(8'h91, 6, 1, 21, 0, -1, "R4 R7 caption good");
    add_gap(3);  add_pkt(8'h55, 9, 4, 16, 0, -1, "R4 vps");
    add_gap(1);  add_pkt(8'h92, 1, 2, 9, 0, -1, "R3 bad identifier");
    add_gap(1);  add_pkt(8'h91, 5, 2, 12, 0, -1, "R4 R8 unknown service");
    add_gap(1);  add_pkt(8'h91, 6, 1, 21, 1, -1, "R7 R8 caption byte 0 parity");
    add_gap(1);  add_pkt(8'h55, 6, 2, 21, 2, -1, "R7 R8 caption byte 1 parity");
    add_gap(1);  add_pkt(8'h91, 6, 0, 21, 0, -1, "R7 caption zero length");
    add_gap(1);  add_pkt(8'h55, 1, 0, 10, 0, -1, "R5 teletext zero length");
    add_gap(1);  add_pkt(8'h91, 1, 2, 8, 0, 1, "R9 abort after id");
    add_pkt(8'h55, 4, 1, 23, 0, -1, "R9 resync after id abort");
    add_pkt(8'h91, 9, 2, 16, 0, 2, "R9 abort after service");
    add_pkt(8'h91, 9, 1, 16, 0, -1, "R9 resync after service abort");
    add_pkt(8'h55, 1, 3, 11, 0, 7, "R9 abort in payload");
    add_pkt(8'h91, 6, 1, 21, 0, -1, "R9 resync after payload abort");
    add_gap(4);
    run_phase(0);

    // Phase B: line offsets
    cur_offs = 9;
    add_gap(2); add_pkt(8'h91, 1, 1, 60, 0, -1, "R6 offset 9");
    add_gap(2); add_pkt(8'h55, 4, 1, 0, 0, -1, "R6 offset 9 line 0");
    run_phase(9);
    cur_offs = 15;
    add_gap(2); add_pkt(8'h91, 6, 1, 63, 0, -1, "R6 offset 15 line 63");
    run_phase(15);

    // Phase C: random packets
    cur_offs = 6;
    for (int k = 0; k < 40; k++) begin
      int nibs[5] = '{1, 4, 6, 9, 0};
      int nib, cnt;
      logic [7:0] did;
      nib = nibs[$urandom_range(0, 4)];
      if (nib == 0) nib = $urandom_range(0, 15);
      cnt = $urandom_range(0, 12);
      did = ($urandom_range(0, 9) == 0) ? 8'h33 : (($urandom_range(0, 1) != 0) ? 8'h91 : 8'h55);
      add_gap($urandom_range(0, 6));
      add_pkt(did, nib, cnt, $urandom_range(0, 63),
              (nib == 6) ? $urandom_range(0, 2) : 0, -1, "R2 R4 R5 R7 random packet");
    end
    run_phase(6);

    n_chk++;
    if (exp_pay.size() != 0 || exp_done.size() != 0) begin
      n_bad++;
      $display("FAIL R5 R9 leftovers: got %0d payload %0d reports pending, expected 0 0",
               exp_pay.size(), exp_done.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule